// File: doc/BRIEF.md
# FIFO-Fed SPI Mode-1 Master

This block is a serial peripheral interface master that frames words with the clock idling low and data launched on the rising edge and captured on the falling edge (polarity 0, phase 1). Software-side logic pushes words into a small transmit FIFO. Whenever the block is enabled and that FIFO is non-empty, it pulls select low, shifts each word out most-significant bit first on `mosi`, and gathers the bits seen on `miso` into a receive FIFO.

The word length is programmable from 4 to 16 bits. A divider value `clkDiv` sets each half of the serial clock to `clkDiv+1` system clocks. Words waiting in the transmit FIFO at the end of a word follow on without releasing select. After the last word, select is released one full serial clock period after the final capture. The length and divider are latched when a transfer starts, so writing them mid-transfer does not disturb it.

Top module: `spi_m1_master`

## Requirements
- R1: While `busy` is low, `sclk` is 0, `ssN` is 1 and `mosi` is 0.
- R2: `ssN` falls only after a clock edge at which `enable` is 1 and the transmit FIFO is non-empty. With `enable` at 0, queued words stay in the FIFO and `ssN` stays high.
- R3: With H = `clkDiv`+1, the first rising edge of `sclk` comes H system clocks after `ssN` falls. Each later half-period of `sclk` also lasts H clocks.
- R4: `mosi` changes only on a rising `sclk` edge while selected, and is stable at the falling edge that samples it. A word of L bits (4 ≤ L ≤ 16, taken from `wordLen`) sends bits `txData[L-1]` down to `txData[0]` in that order.
- R5: For a single word, `ssN` rises 2·H clocks after the last falling `sclk` edge, so `ssN` is low for (2·L+2)·H clocks.
- R6: If a further word is queued when a word ends and `enable` is still 1, `ssN` stays low and the next word's first rising edge comes H clocks after the previous last falling edge. For n words, `ssN` is low once, for (2·L·n+2)·H clocks.
- R7: Each received word is stored right-justified: the first bit sampled lands in bit L-1, the last in bit 0, and bits 15 down to L are zero. Words leave `rxData` in arrival order, first-word fall-through.
- R8: A received word that finds the receive FIFO full is discarded and sets `rxOverrun`, which stays 1 until reset.
- R9: `busy` equals the inverse of `ssN`. Changes to `wordLen` or `clkDiv` while `busy` is high have no effect on the transfer in progress and take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows transfers to start or continue |
| wordLen | input | 5 | Word length in bits, 4 to 16 |
| clkDiv | input | 8 | Half-period of `sclk` minus one, in system clocks |
| txPush | input | 1 | Write `txData` into the transmit FIFO |
| txData | input | 16 | Word to transmit, right-justified |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxPop | input | 1 | Remove the head of the receive FIFO |
| rxData | output | 16 | Head of the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxOverrun | output | 1 | Sticky: a received word was dropped |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps every word length from 4 to 16 against four divider values. For each run it measures the select-to-first-edge delay and the select-low time. A counter that was off by one would stretch or shrink these by a whole half-period, and a release taken at the last falling edge would shorten select by 2·H. Bursts of two to four queued words check that select never toggles between words; a design that reloads through idle would show extra select pulses and a longer total. Further runs change the length and divider mid-transfer, hold `enable` low over a queued word, and overfill the receive FIFO. An unlatched configuration would corrupt the bit count, an ungated start would select with `enable` low, and a missing full check would overwrite stored words instead of setting the overrun flag.

// File: rtl/spi_m1_pkg.sv
package spi_m1_pkg;
  // one-cycle strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;        // fetch a word from the transmit FIFO, no launch yet
    logic launch;      // put the next bit on mosi (rising sclk)
    logic loadLaunch;  // fetch a word and put its first bit on mosi at once
    logic sample;      // capture miso (falling sclk)
    logic lastSample;  // this capture completes the word
    logic dropSel;     // select is being released, park mosi low
  } spiStrobe_t;
endpackage

// File: rtl/spi_m1_fifo.sv
module spi_m1_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic wrEn, rdEn;

  assign wrEn  = push && !full;
  assign rdEn  = pop && !empty;
  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dout  = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + (AW+1)'(1);
      if (rdEn) rdPtr <= rdPtr + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/spi_m1_datapath.sv
module spi_m1_datapath
  import spi_m1_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int LEN_W = $clog2(WORD_W + 1),
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strb,
  input  logic [LEN_W-1:0]  lenL,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txShift, rxShift;
  logic [IDX_W-1:0]  msbIdx;

  // top bit of the active frame inside the shift register
  assign msbIdx = IDX_W'(lenL - LEN_W'(1));
  // word as it stands once the current miso bit is taken in
  assign rxWord = {rxShift[WORD_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      mosi    <= 1'b0;
    end else begin
      if (strb.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end
      if (strb.loadLaunch) begin
        mosi    <= txWord[msbIdx];
        txShift <= txWord << 1;
        rxShift <= '0;
      end
      if (strb.launch) begin
        mosi    <= txShift[msbIdx];
        txShift <= txShift << 1;
      end
      if (strb.sample) rxShift <= rxWord;
      if (strb.dropSel) mosi <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_m1_ctrl.sv
module spi_m1_ctrl
  import spi_m1_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [LEN_W-1:0] wordLen,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             txEmpty,
  input  logic             rxFull,
  output spiStrobe_t       strb,
  output logic [LEN_W-1:0] lenL,
  output logic             sclk,
  output logic             ssN,
  output logic             busy,
  output logic             overrun
);
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TAIL} phase_t;

  phase_t           state;
  logic [DIV_W-1:0] cnt, divL;
  logic [LEN_W-1:0] bitCnt;
  logic             halfDone, haveWord;

  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v);
    if (v < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
    if (v > LEN_W'(WORD_W))  return LEN_W'(WORD_W);
    return v;
  endfunction

  assign halfDone = (cnt == divL);
  assign haveWord = enable && !txEmpty;
  assign busy     = (state != S_IDLE);

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE: strb.load = haveWord;
      S_LEAD: strb.launch = halfDone;
      S_HIGH: begin
        strb.sample     = halfDone;
        strb.lastSample = halfDone && (bitCnt == '0);
      end
      S_LOW: if (halfDone) begin
        if (bitCnt != '0) strb.launch = 1'b1;
        else              strb.loadLaunch = haveWord;
      end
      S_TAIL: strb.dropSel = halfDone;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      divL    <= '0;
      lenL    <= LEN_W'(MIN_LEN);
      bitCnt  <= '0;
      sclk    <= 1'b0;
      ssN     <= 1'b1;
      overrun <= 1'b0;
    end else begin
      cnt <= (state == S_IDLE || halfDone) ? '0 : cnt + DIV_W'(1);
      case (state)
        S_IDLE: if (haveWord) begin
          state <= S_LEAD;
          ssN   <= 1'b0;
          lenL  <= clampLen(wordLen);
          divL  <= clkDiv;
        end
        S_LEAD: if (halfDone) begin
          state  <= S_HIGH;
          sclk   <= 1'b1;
          bitCnt <= lenL - LEN_W'(1);
        end
        S_HIGH: if (halfDone) begin
          state <= S_LOW;
          sclk  <= 1'b0;
        end
        S_LOW: if (halfDone) begin
          if (bitCnt != '0) begin
            state  <= S_HIGH;
            sclk   <= 1'b1;
            bitCnt <= bitCnt - LEN_W'(1);
          end else if (haveWord) begin
            state  <= S_HIGH;
            sclk   <= 1'b1;
            bitCnt <= lenL - LEN_W'(1);
          end else begin
            state <= S_TAIL;
          end
        end
        S_TAIL: if (halfDone) begin
          state <= S_IDLE;
          ssN   <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
      if (strb.lastSample && rxFull) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_m1_master.sv
module spi_m1_master
  import spi_m1_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int MIN_LEN  = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int DIV_W    = 8,
  localparam int LEN_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              txPush,
  input  logic [WORD_W-1:0] txData,
  output logic              txFull,
  output logic              txEmpty,
  input  logic              rxPop,
  output logic [WORD_W-1:0] rxData,
  output logic              rxEmpty,
  output logic              rxOverrun,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN,
  output logic              busy
);
  spiStrobe_t        strb;
  logic [LEN_W-1:0]  lenL;
  logic [WORD_W-1:0] txHead, rxWord;
  logic              rxFull;

  spi_m1_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(txPush), .din(txData),
    .pop(strb.load || strb.loadLaunch),
    .dout(txHead), .full(txFull), .empty(txEmpty)
  );

  spi_m1_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.lastSample), .din(rxWord),
    .pop(rxPop),
    .dout(rxData), .full(rxFull), .empty(rxEmpty)
  );

  spi_m1_ctrl #(.WORD_W(WORD_W), .MIN_LEN(MIN_LEN), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .wordLen(wordLen), .clkDiv(clkDiv),
    .txEmpty(txEmpty), .rxFull(rxFull),
    .strb(strb), .lenL(lenL),
    .sclk(sclk), .ssN(ssN), .busy(busy), .overrun(rxOverrun)
  );

  spi_m1_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lenL(lenL),
    .txWord(txHead), .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_m1_checker.sv
module spi_m1_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txEmpty,
  input logic sclk,
  input logic mosi,
  input logic ssN,
  input logic busy,
  input logic rxOverrun
);
  // R1: quiet levels whenever no transfer is running
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclk && ssN && !mosi));

  // R2: select only falls after an edge that saw enable and a queued word
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> ($past(enable) && !$past(txEmpty)));

  // R3: the serial clock only toggles inside a selected frame
  p_clock_inside_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !ssN);

  // R4: while selected, data moves only together with a rising sclk
  p_launch_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ssN && !$stable(mosi)) |-> $rose(sclk));

  // R8: the overrun flag never clears on its own
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  // R9: busy covers exactly the select-low window
  p_busy_matches_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy == !ssN);
endmodule

bind spi_m1_master spi_m1_checker u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .txEmpty(txEmpty),
  .sclk(sclk), .mosi(mosi), .ssN(ssN), .busy(busy), .rxOverrun(rxOverrun)
);

// File: tb/tb_spi_m1_master.sv
module tb_spi_m1_master;
  logic        clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic        txPush = 1'b0, rxPop = 1'b0, miso = 1'b0;
  logic [4:0]  wordLen = 5'd8;
  logic [7:0]  clkDiv = 8'd0;
  logic [15:0] txData = '0;
  logic        txFull, txEmpty, rxEmpty, rxOverrun, sclk, mosi, ssN, busy;
  logic [15:0] rxData;

  spi_m1_master dut (
    .clk(clk), .rstN(rstN), .enable(enable), .wordLen(wordLen), .clkDiv(clkDiv),
    .txPush(txPush), .txData(txData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .rxOverrun(rxOverrun),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN), .busy(busy)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // line monitor and slave model, sampled away from the active edge
  int ssFallCyc, ssRiseCyc, firstRiseCyc, ssFalls = 0, ssRises = 0;
  int idleBad = 0, busyBad = 0, wIdx = 0, bIdx = 0, curLen = 8;
  logic [15:0] mosiW [8];
  logic [15:0] slaveW [8];
  logic [15:0] pend [$];
  logic pSs = 1'b1, pSclk = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pSs && !ssN) begin
        ssFallCyc = cyc; ssFalls++; wIdx = 0; bIdx = 0; firstRiseCyc = -1;
        for (int k = 0; k < 8; k++) mosiW[k] = '0;
      end
      if (!pSclk && sclk) begin
        if (firstRiseCyc < 0) firstRiseCyc = cyc;
        miso = slaveW[wIdx & 7][curLen-1-bIdx];
      end
      if (pSclk && !sclk) begin
        mosiW[wIdx & 7] = {mosiW[wIdx & 7][14:0], mosi};
        bIdx++;
        if (bIdx == curLen) begin bIdx = 0; wIdx++; end
      end
      if (!pSs && ssN) begin ssRiseCyc = cyc; ssRises++; end
      if (!busy && (sclk || !ssN || mosi)) idleBad++;
      if (busy != !ssN) busyBad++;
      pSs = ssN; pSclk = sclk;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] txFor(input int len, input int div, input int k);
    return 16'h5A3C ^ 16'(len * 16'h0111) ^ 16'(k * 16'h1357) ^ 16'(div * 16'h0F0F);
  endfunction
  function automatic logic [15:0] slaveFor(input int len, input int div, input int k);
    return ~txFor(len, div, k) ^ 16'h2468 ^ 16'(k * 16'h0321);
  endfunction
  function automatic logic [15:0] maskOf(input int len);
    return 16'((32'h1 << len) - 1);
  endfunction

  task automatic runXfer(input int len, input int div, input int n, input bit mid, input bit pushNow);
    int r0, guard, h;
    h = div + 1;
    wordLen = 5'(len); clkDiv = 8'(div); curLen = len;
    for (int k = 0; k < n; k++) slaveW[k] = slaveFor(len, div, k);
    if (pushNow) begin
      for (int k = 0; k < n; k++) begin
        @(negedge clk); txPush = 1'b1; txData = txFor(len, div, k);
      end
      @(negedge clk); txPush = 1'b0;
    end
    r0 = ssRises;
    @(negedge clk); enable = 1'b1;
    if (mid) begin
      repeat (3) @(negedge clk);
      wordLen = (len == 16) ? 5'd5 : 5'd16;  // R9: changed while busy
      clkDiv  = 8'(div + 2);
    end
    guard = 0;
    while (ssRises == r0 && guard < 20000) begin @(negedge clk); guard++; end
    enable = 1'b0;
    if (guard >= 20000) chk("R5 watchdog", 0, 1);
    chk("R3 first edge", firstRiseCyc - ssFallCyc, h);
    chk((n > 1) ? "R6 select time" : "R5 select time", ssRiseCyc - ssFallCyc, (2*len*n + 2) * h);
    chk("R6 one select pulse", ssRises - r0, 1);
    for (int k = 0; k < n; k++) begin
      chk("R4 mosi word", mosiW[k], txFor(len, div, k) & maskOf(len));
      pend.push_back(slaveFor(len, div, k) & maskOf(len));
    end
  endtask

  task automatic popAll();
    int cnt = 0;
    while (!rxEmpty && cnt < 16) begin
      if (pend.size() > 0) chk("R7 rx word", rxData, pend.pop_front());
      else chk("R7 unexpected rx word", 1, 0);
      @(negedge clk); rxPop = 1'b1;
      @(negedge clk); rxPop = 1'b0;
      cnt++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset sclk", sclk, 0);
    chk("R1 reset ssN", ssN, 1);
    chk("R1 reset mosi", mosi, 0);
    chk("R9 reset busy", busy, 0);
    chk("R7 reset rxEmpty", rxEmpty, 1);

    // every length against several dividers, single words
    for (int len = 4; len <= 16; len++)
      for (int div = 0; div < 4; div++) begin
        runXfer(len, div, 1, 1'b0, 1'b1);
        popAll();
        chk("R7 all words drained", pend.size(), 0);
      end

    // back-to-back bursts (R6)
    runXfer(8, 1, 3, 1'b0, 1'b1);  popAll();
    runXfer(16, 0, 4, 1'b0, 1'b1); popAll();
    runXfer(4, 2, 2, 1'b0, 1'b1);  popAll();
    chk("R6 bursts drained", pend.size(), 0);

    // R2: a queued word waits while enable is low
    wordLen = 5'd7; clkDiv = 8'd1; curLen = 7;
    f0 = ssFalls;
    @(negedge clk); txPush = 1'b1; txData = txFor(7, 1, 0);
    @(negedge clk); txPush = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2 no select while disabled", ssFalls, f0);
    chk("R2 word still queued", txEmpty, 0);
    chk("R2 not busy", busy, 0);
    runXfer(7, 1, 1, 1'b0, 1'b0);
    popAll();

    // R9: configuration written mid-transfer is ignored until the next start
    runXfer(8, 1, 1, 1'b1, 1'b1);  popAll();
    runXfer(16, 0, 1, 1'b1, 1'b1); popAll();
    runXfer(5, 0, 1, 1'b0, 1'b1);  popAll();
    chk("R9 drained", pend.size(), 0);

    // R8: overfill the receive side
    chk("R8 no overrun yet", rxOverrun, 0);
    runXfer(6, 0, 3, 1'b0, 1'b1);
    chk("R8 three stored, no overrun", rxOverrun, 0);
    runXfer(6, 0, 3, 1'b0, 1'b1);
    chk("R8 overrun after overflow", rxOverrun, 1);
    popAll();
    chk("R8 two words dropped", pend.size(), 2);
    pend.delete();
    chk("R8 overrun sticky after drain", rxOverrun, 1);

    chk("R1 idle level violations", idleBad, 0);
    chk("R9 busy vs select mismatches", busyBad, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule